// File: doc/BRIEF.md
# Per-Channel Secure Register Access Guard

This block sits between a register bus and the register storage of a multi-channel request routing unit. For every access it decides whether the access may touch the target register. The decision uses two attributes of the access, secure or non-secure and privileged or unprivileged, together with per-channel secure and privileged inputs. Those inputs are driven by the configuration of the attached DMA channels. Writes pass downstream as a per-bit write mask. Read data from the storage is masked to zero wherever the access is not entitled to see it.

Each channel configuration register is judged as a whole against its own channel. The shared status and clear registers hold one bit per channel, so they are judged bit by bit. A request-generator configuration register inherits the attributes of the multiplexer channel that selects that generator.

When a non-secure access reaches the configuration register of a secure channel, the block emits a one-cycle illegal-access pulse. It also routes each channel's overrun indication to a secure or a non-secure interrupt output.

Top module: `chan_access_guard`

## Requirements
- R1: A secure, privileged, aligned access to any mapped register has every bit of its byte lanes passed: the write mask equals the lane mask, and read data equals the raw data within the lanes.
- R2: A non-secure access to the configuration register of a secure channel is blocked. The write mask is zero and the read data is zero.
- R3: An unprivileged access to the configuration register of a privileged channel is blocked (zero write mask, zero read data) and raises no illegal-access pulse unless R4 also applies.
- R4: One cycle after an aligned, non-secure access to the configuration register of a secure multiplexer or generator channel, `illegal_pulse` is high for that cycle only. No other access raises it.
- R5: In the shared sync status (word 0x080), sync clear (0x084), generator status (0x140) and generator clear (0x144) registers, bit i passes only if the access may reach channel i (multiplexer channel i for the first two, generator i for the last two). Bits above the channel count never pass. These registers never raise the pulse.
- R6: Generator g (at 0x100+4g) is owned by the lowest-numbered multiplexer channel whose select value equals g+1, and takes that channel's secure and privileged state. A generator that no channel selects is open to every access.
- R7: Size 0 is a byte, size 1 a halfword and size 2 a word. Lanes follow addr[1:0]. A halfword with addr[0]=1, a word with addr[1:0]≠0, or size 3 is rejected: no write, read zero, no pulse.
- R8: Unmapped addresses, and configuration slots at or above the channel or generator count, give a zero write mask and zero read data.
- R9: `irq_sec` and `irq_nsec` are registered one cycle after the overrun inputs. An overrun on a secure multiplexer channel or a secure-owned generator drives `irq_sec`; any other overrun drives `irq_nsec`.
- R10: During and right after reset, `illegal_pulse`, `irq_sec` and `irq_nsec` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | ADDR_W | Byte address |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_nonsec | input | 1 | 1 non-secure access, 0 secure |
| acc_priv | input | 1 | 1 privileged access |
| rd_raw | input | 32 | Unfiltered read data from storage |
| chan_sec | input | NCH | Secure state per multiplexer channel |
| chan_priv | input | NCH | Privileged state per multiplexer channel |
| chan_sel | input | NCH*SEL_W | Request select value per multiplexer channel |
| sync_ovr | input | NCH | Overrun indication per multiplexer channel |
| gen_ovr | input | NGEN | Overrun indication per generator |
| rd_data | output | 32 | Filtered read data |
| wr_en | output | 1 | Some bit of the write takes effect |
| wr_mask | output | 32 | Per-bit write permission |
| illegal_pulse | output | 1 | One-cycle illegal-access pulse |
| irq_sec | output | 1 | Secure overrun interrupt |
| irq_nsec | output | 1 | Non-secure overrun interrupt |

## Verification
The bench sweeps every combination of channel security and privilege, every access attribute pair, and every mapped and unmapped word, in both read and write form. A guard that judged shared registers as a whole would expose or hide whole words, where each bit should follow its own channel. A guard that pulsed on shared registers would raise false alarms when all channels are secure. The bench also covers generators with two claiming channels and with none, so wrong ownership priority or a locked-out free generator shows up. A size and offset sweep catches lane errors and misaligned accesses that slip through. The interrupt test exercises each overrun source and shows misrouting between the secure and non-secure outputs.

// File: rtl/cag_pkg.sv
`timescale 1ns/1ps
package cag_pkg;
  localparam int DATA_W     = 32;
  localparam int IDX_W      = 5;
  // word addresses of the register map
  localparam int MCFG_SLOTS = 32;
  localparam int WA_SSTAT   = 32;
  localparam int WA_SCLR    = 33;
  localparam int WA_GCFG    = 64;
  localparam int GCFG_SLOTS = 16;
  localparam int WA_GSTAT   = 80;
  localparam int WA_GCLR    = 81;

  typedef enum logic [2:0] {
    RG_NONE, RG_MCFG, RG_SSTAT, RG_SCLR, RG_GCFG, RG_GSTAT, RG_GCLR
  } region_e;

  function automatic logic may_reach(input logic tgt_sec, input logic tgt_priv,
                                     input logic nonsec, input logic priv);
    return (!tgt_sec || !nonsec) && (!tgt_priv || priv);
  endfunction
endpackage

// File: rtl/cag_decode.sv
`timescale 1ns/1ps
module cag_decode
  import cag_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          size,
  output region_e             region,
  output logic [IDX_W-1:0]    idx,
  output logic [DATA_W-1:0]   lane,
  output logic                aligned
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] waddr;
  assign waddr = addr[ADDR_W-1:2];

  always_comb begin
    region = RG_NONE;
    idx    = '0;
    if (waddr < WA_W'(MCFG_SLOTS)) begin
      region = RG_MCFG;
      idx    = IDX_W'(waddr);
    end else if (waddr == WA_W'(WA_SSTAT)) begin
      region = RG_SSTAT;
    end else if (waddr == WA_W'(WA_SCLR)) begin
      region = RG_SCLR;
    end else if (waddr >= WA_W'(WA_GCFG) && waddr < WA_W'(WA_GCFG + GCFG_SLOTS)) begin
      region = RG_GCFG;
      idx    = IDX_W'(waddr - WA_W'(WA_GCFG));
    end else if (waddr == WA_W'(WA_GSTAT)) begin
      region = RG_GSTAT;
    end else if (waddr == WA_W'(WA_GCLR)) begin
      region = RG_GCLR;
    end
  end

  always_comb begin
    case (size)
      2'd0: begin
        aligned = 1'b1;
        lane    = 32'h0000_00FF << {addr[1:0], 3'b000};
      end
      2'd1: begin
        aligned = ~addr[0];
        lane    = addr[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
      end
      2'd2: begin
        aligned = (addr[1:0] == 2'b00);
        lane    = '1;
      end
      default: begin
        aligned = 1'b0;
        lane    = '0;
      end
    endcase
  end

  // R7: an accepted size selects exactly one byte, two bytes or four bytes
  p_lane_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |-> ($countones(lane) == 8 || $countones(lane) == 16 || $countones(lane) == 32));
endmodule

// File: rtl/cag_owner.sv
`timescale 1ns/1ps
module cag_owner #(
  parameter int NCH   = 4,
  parameter int NGEN  = 2,
  parameter int SEL_W = 8
) (
  input  logic [NCH-1:0]       chan_sec,
  input  logic [NCH-1:0]       chan_priv,
  input  logic [NCH*SEL_W-1:0] chan_sel,
  output logic [NGEN-1:0]      gen_sec,
  output logic [NGEN-1:0]      gen_priv
);
  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    always_comb begin
      gen_sec[g]  = 1'b0;
      gen_priv[g] = 1'b0;
      // descending scan: the lowest claiming channel is applied last and wins
      for (int c = NCH - 1; c >= 0; c--) begin
        if (chan_sel[c*SEL_W +: SEL_W] == SEL_W'(g + 1)) begin
          gen_sec[g]  = chan_sec[c];
          gen_priv[g] = chan_priv[c];
        end
      end
    end
  end
endmodule

// File: rtl/cag_irq_split.sv
`timescale 1ns/1ps
module cag_irq_split #(
  parameter int NCH  = 4,
  parameter int NGEN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  chan_sec,
  input  logic [NGEN-1:0] gen_sec,
  input  logic [NCH-1:0]  sync_ovr,
  input  logic [NGEN-1:0] gen_ovr,
  output logic            irq_sec,
  output logic            irq_nsec
);
  logic sec_d, nsec_d;

  always_comb begin
    sec_d  = |(sync_ovr & chan_sec) | |(gen_ovr & gen_sec);
    nsec_d = |(sync_ovr & ~chan_sec) | |(gen_ovr & ~gen_sec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_sec  <= 1'b0;
      irq_nsec <= 1'b0;
    end else begin
      irq_sec  <= sec_d;
      irq_nsec <= nsec_d;
    end
  end

  // R9: an interrupt output only follows an overrun seen the cycle before
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sec || irq_nsec) |-> $past((|sync_ovr) || (|gen_ovr)));
endmodule

// File: rtl/chan_access_guard.sv
`timescale 1ns/1ps
module chan_access_guard
  import cag_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int NGEN   = 2,
  parameter int SEL_W  = 8,
  parameter int ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [1:0]           acc_size,
  input  logic                 acc_nonsec,
  input  logic                 acc_priv,
  input  logic [31:0]          rd_raw,
  input  logic [NCH-1:0]       chan_sec,
  input  logic [NCH-1:0]       chan_priv,
  input  logic [NCH*SEL_W-1:0] chan_sel,
  input  logic [NCH-1:0]       sync_ovr,
  input  logic [NGEN-1:0]      gen_ovr,
  output logic [31:0]          rd_data,
  output logic                 wr_en,
  output logic [31:0]          wr_mask,
  output logic                 illegal_pulse,
  output logic                 irq_sec,
  output logic                 irq_nsec
);
  region_e            region;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  lane;
  logic               aligned;
  logic [NGEN-1:0]    gen_sec, gen_priv;
  logic [NCH-1:0]     chan_ok;
  logic [NGEN-1:0]    gen_ok;
  logic [DATA_W-1:0]  perm, eff;
  logic               tgt_sec, is_cfg, pulse_d;

  cag_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(acc_addr), .size(acc_size),
    .region(region), .idx(idx), .lane(lane), .aligned(aligned)
  );

  cag_owner #(.NCH(NCH), .NGEN(NGEN), .SEL_W(SEL_W)) u_own (
    .chan_sec(chan_sec), .chan_priv(chan_priv), .chan_sel(chan_sel),
    .gen_sec(gen_sec), .gen_priv(gen_priv)
  );

  cag_irq_split #(.NCH(NCH), .NGEN(NGEN)) u_irq (
    .clk(clk), .rst_n(rst_n), .chan_sec(chan_sec), .gen_sec(gen_sec),
    .sync_ovr(sync_ovr), .gen_ovr(gen_ovr), .irq_sec(irq_sec), .irq_nsec(irq_nsec)
  );

  always_comb begin
    for (int c = 0; c < NCH; c++)
      chan_ok[c] = may_reach(chan_sec[c], chan_priv[c], acc_nonsec, acc_priv);
    for (int g = 0; g < NGEN; g++)
      gen_ok[g] = may_reach(gen_sec[g], gen_priv[g], acc_nonsec, acc_priv);
  end

  // whole-register verdict for configuration words, per-bit for shared words
  always_comb begin
    perm    = '0;
    tgt_sec = 1'b0;
    case (region)
      RG_MCFG: begin
        for (int c = 0; c < NCH; c++) begin
          if (idx == IDX_W'(c)) begin
            perm    = {DATA_W{chan_ok[c]}};
            tgt_sec = chan_sec[c];
          end
        end
      end
      RG_GCFG: begin
        for (int g = 0; g < NGEN; g++) begin
          if (idx == IDX_W'(g)) begin
            perm    = {DATA_W{gen_ok[g]}};
            tgt_sec = gen_sec[g];
          end
        end
      end
      RG_SSTAT, RG_SCLR: perm = DATA_W'(chan_ok);
      RG_GSTAT, RG_GCLR: perm = DATA_W'(gen_ok);
      default:           perm = '0;
    endcase
  end

  always_comb begin
    is_cfg  = (region == RG_MCFG) || (region == RG_GCFG);
    eff     = (acc_valid && aligned) ? (perm & lane) : '0;
    wr_mask = acc_write ? eff : '0;
    wr_en   = |wr_mask;
    rd_data = acc_write ? '0 : (rd_raw & eff);
    pulse_d = acc_valid && aligned && acc_nonsec && is_cfg && tgt_sec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_pulse <= 1'b0;
    else        illegal_pulse <= pulse_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R2: non-secure access to a secure channel's configuration word sees nothing
    p_nonsec_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_nonsec && region == RG_MCFG && idx == IDX_W'(c) && chan_sec[c])
        |-> (wr_mask == '0 && rd_data == '0));
    // R3: unprivileged access to a privileged channel's configuration word sees nothing
    p_unpriv_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_priv && region == RG_MCFG && idx == IDX_W'(c) && chan_priv[c])
        |-> (wr_mask == '0 && rd_data == '0));
  end

  // R4: a pulse is always preceded by a non-secure access
  p_pulse_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_pulse |-> $past(acc_valid && acc_nonsec));

  // R5: shared status and clear words never raise the pulse
  p_shared_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (region == RG_SSTAT || region == RG_SCLR ||
                   region == RG_GSTAT || region == RG_GCLR)) |=> !illegal_pulse);

  // R7: no write bit outside the lanes, nothing passes on a rejected size
  p_lane_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask & ~lane) == '0);
  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> (!wr_en && rd_data == '0));

  // R8: unmapped words give nothing
  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_NONE) |-> (!wr_en && rd_data == '0));
endmodule

// File: tb/tb_chan_access_guard.sv
`timescale 1ns/1ps
module tb_chan_access_guard;
  localparam int NCH = 4, NGEN = 2, SEL_W = 8, ADDR_W = 10;
  localparam int LIMIT = 180000;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, acc_write, acc_nonsec, acc_priv;
  logic [ADDR_W-1:0] acc_addr;
  logic [1:0] acc_size;
  logic [31:0] rd_raw;
  logic [NCH-1:0] sec_v, priv_v, sync_ovr;
  logic [NGEN-1:0] gen_ovr;
  logic [SEL_W-1:0] sel_v [NCH];
  logic [NCH*SEL_W-1:0] chan_sel;
  logic [31:0] rd_data, wr_mask;
  logic wr_en, illegal_pulse, irq_sec, irq_nsec;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb
    for (int c = 0; c < NCH; c++) chan_sel[c*SEL_W +: SEL_W] = sel_v[c];

  chan_access_guard #(.NCH(NCH), .NGEN(NGEN), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_nonsec(acc_nonsec), .acc_priv(acc_priv),
    .rd_raw(rd_raw), .chan_sec(sec_v), .chan_priv(priv_v), .chan_sel(chan_sel),
    .sync_ovr(sync_ovr), .gen_ovr(gen_ovr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_mask(wr_mask), .illegal_pulse(illegal_pulse), .irq_sec(irq_sec), .irq_nsec(irq_nsec)
  );

  task automatic check(input string tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic reach(input logic s, input logic p, input logic ns, input logic pr);
    if (s && ns) return 1'b0;
    if (p && !pr) return 1'b0;
    return 1'b1;
  endfunction

  // R6 model: generator attributes from the lowest claiming channel
  task automatic gen_attr(input int g, output logic s, output logic p);
    s = 1'b0; p = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (int'(sel_v[c]) == g + 1) begin
        s = sec_v[c]; p = priv_v[c];
        return;
      end
    end
  endtask

  task automatic model(input int a, input int sz, input logic ns, input logic pr,
                       output logic [31:0] perm, output logic [31:0] lane,
                       output logic pls, output string tag);
    int w;
    logic gs, gp, okal;
    w = a / 4;
    perm = '0; pls = 1'b0; tag = "R8";
    if (w < 32) begin
      if (w < NCH) begin
        perm = reach(sec_v[w], priv_v[w], ns, pr) ? '1 : '0;
        pls  = ns && sec_v[w];
        if (ns && sec_v[w]) tag = "R2";
        else if (priv_v[w] && !pr) tag = "R3";
        else tag = "R1";
      end
    end else if (w == 32 || w == 33) begin
      tag = "R5";
      for (int c = 0; c < NCH; c++) perm[c] = reach(sec_v[c], priv_v[c], ns, pr);
    end else if (w >= 64 && w < 80) begin
      if (w - 64 < NGEN) begin
        gen_attr(w - 64, gs, gp);
        perm = reach(gs, gp, ns, pr) ? '1 : '0;
        pls  = ns && gs;
        tag  = "R6";
      end
    end else if (w == 80 || w == 81) begin
      tag = "R5";
      for (int g = 0; g < NGEN; g++) begin
        gen_attr(g, gs, gp);
        perm[g] = reach(gs, gp, ns, pr);
      end
    end
    okal = 1'b1;
    case (sz)
      0: lane = 32'hFF << (8 * (a % 4));
      1: begin okal = (a % 2 == 0); lane = (a % 4 >= 2) ? 32'hFFFF_0000 : 32'h0000_FFFF; end
      2: begin okal = (a % 4 == 0); lane = '1; end
      default: begin okal = 1'b0; lane = '0; end
    endcase
    if (!okal) begin lane = '0; pls = 1'b0; end
  endtask

  task automatic do_acc(input int a, input int sz, input logic wr, input logic ns,
                        input logic pr, input string force_tag);
    logic [31:0] perm, lane, raw, exp_m;
    logic pls;
    string tag;
    model(a, sz, ns, pr, perm, lane, pls, tag);
    if (force_tag != "") tag = force_tag;
    raw = 32'hA5C3_96E1 ^ (a * 32'h0001_0203);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = ADDR_W'(a); acc_size = 2'(sz);
    acc_nonsec = ns; acc_priv = pr; rd_raw = raw;
    #3;
    exp_m = perm & lane;
    check(tag, "wr_mask", wr_mask, wr ? exp_m : 32'h0);
    check(tag, "wr_en", {31'b0, wr_en}, {31'b0, wr && (exp_m != 0)});
    check(tag, "rd_data", rd_data, wr ? 32'h0 : (raw & exp_m));
    @(negedge clk);
    acc_valid = 1'b0;
    #1;
    check("R4", "illegal_pulse", {31'b0, illegal_pulse}, {31'b0, pls});
  endtask

  int addrs_a [13] = '{'h000, 'h004, 'h008, 'h00C, 'h010, 'h080, 'h084,
                       'h100, 'h104, 'h108, 'h140, 'h144, 'h0C0};
  int addrs_b [4]  = '{'h100, 'h104, 'h140, 'h144};

  task automatic irq_case(input logic [NCH-1:0] so, input logic [NGEN-1:0] go);
    logic es, en, gs, gp;
    es = 1'b0; en = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (so[c]) begin if (sec_v[c]) es = 1'b1; else en = 1'b1; end
    for (int g = 0; g < NGEN; g++)
      if (go[g]) begin gen_attr(g, gs, gp); if (gs) es = 1'b1; else en = 1'b1; end
    @(negedge clk);
    sync_ovr = so; gen_ovr = go;
    @(negedge clk);
    check("R9", "irq_sec", {31'b0, irq_sec}, {31'b0, es});
    check("R9", "irq_nsec", {31'b0, irq_nsec}, {31'b0, en});
    sync_ovr = '0; gen_ovr = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual cycles %0d expected below %0d", cyc, LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_size = 2'd2;
    acc_nonsec = 1'b0; acc_priv = 1'b1; rd_raw = '0; sec_v = '0; priv_v = '0;
    sync_ovr = '0; gen_ovr = '0;
    for (int c = 0; c < NCH; c++) sel_v[c] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "illegal_pulse", {31'b0, illegal_pulse}, 32'h0);
    check("R10", "irq_sec", {31'b0, irq_sec}, 32'h0);
    check("R10", "irq_nsec", {31'b0, irq_nsec}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "illegal_pulse after release", {31'b0, illegal_pulse}, 32'h0);

    // configuration A: gen0 claimed by ch2, gen1 by ch1 and ch3 (ch1 wins, R6)
    sel_v[0] = 8'd5; sel_v[1] = 8'd2; sel_v[2] = 8'd1; sel_v[3] = 8'd2;
    for (int s = 0; s < 16; s++)
      for (int p = 0; p < 16; p++) begin
        sec_v = NCH'(s); priv_v = NCH'(p);
        for (int at = 0; at < 4; at++)
          for (int i = 0; i < 13; i++)
            for (int wr = 0; wr < 2; wr++)
              do_acc(addrs_a[i], 2, wr[0], at[1], at[0], "");
      end

    // configuration B: gen1 unclaimed (open, R6), gen0 claimed by ch3
    sel_v[0] = 8'd7; sel_v[1] = 8'd9; sel_v[2] = 8'd0; sel_v[3] = 8'd1;
    for (int s = 0; s < 16; s++)
      for (int p = 0; p < 16; p++) begin
        sec_v = NCH'(s); priv_v = NCH'(p);
        for (int at = 0; at < 4; at++)
          for (int i = 0; i < 4; i++)
            for (int wr = 0; wr < 2; wr++)
              do_acc(addrs_b[i], 2, wr[0], at[1], at[0], "");
      end

    // R7: size and offset sweep on an open register and on a secure one
    for (int k = 0; k < 2; k++) begin
      sec_v = k[0] ? 4'b0010 : 4'b0000; priv_v = '0;
      for (int off = 0; off < 4; off++)
        for (int sz = 0; sz < 4; sz++)
          for (int wr = 0; wr < 2; wr++)
            do_acc(4 + off, sz, wr[0], k[0], 1'b1, "R7");
    end

    // R9: interrupt routing, configuration A ownership
    sel_v[0] = 8'd5; sel_v[1] = 8'd2; sel_v[2] = 8'd1; sel_v[3] = 8'd2;
    sec_v = 4'b0101;
    irq_case(4'b0001, 2'b00);
    irq_case(4'b0010, 2'b00);
    irq_case(4'b0000, 2'b01);
    irq_case(4'b0000, 2'b10);
    irq_case(4'b1010, 2'b01);
    irq_case(4'b0000, 2'b00);
    sec_v = 4'b0000;
    irq_case(4'b0000, 2'b11);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule